// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block sits between twelve interrupt request lines and a processor core. It picks one request at a time and presents it to the core as a request flag with a vector index. It holds that pair until the core acknowledges it. Eleven of the lines are ordinary sources. Each ordinary source has an enable bit and a priority bit that software writes through a small register bus, and the priority bit places the source on the low tier or the high tier. The twelfth line is the power-management source. It lives alone on a third tier above both programmable tiers, so it can break into any running handler.

The controller tracks nesting with one in-service flag per tier. An acknowledge sets the flag for the tier of the vector just taken. A return-from-interrupt pulse clears the highest flag that is set. A pending line is only offered to the core when its tier is strictly above the highest tier now in service. The result is that a high-tier request breaks into a low-tier handler, the power-management request breaks into either, and no handler is interrupted by a peer of its own tier.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the enable, priority and extension registers read 0x00 and `irq_req` is low.
- R2: Register 0 holds the global enable in bit 7 and the enables of lines 6..0 in bits 6..0. The line-to-source mapping is: line 0 external 0, line 1 timer 0, line 2 external 1, line 3 timer 1, line 4 serial port, line 5 timer 2, line 6 temperature converter. An ordinary line is offered only when its own enable bit and the global bit are both 1.
- R3: While the global enable bit is 0, no ordinary line (0..10) is offered, whatever its own enable bit holds.
- R4: Line 11 is the power-management source. It is offered with vector 11 whatever the register contents are.
- R5: When lines of different tiers are pending together, the one on the higher tier is offered first. The tier order, highest first, is power-management, high, low.
- R6: Among pending lines of one tier, the lowest line number is offered first.
- R7: Register 1 bits 6..0 set lines 6..0 to the high tier when 1. Register 2 bits 3..0 enable lines 7..10, and register 2 bits 7..4 set lines 7..10 to the high tier.
- R8: A high-tier line is offered while a low-tier handler is in service. The power-management line is offered while a high-tier handler is in service.
- R9: A line whose tier is at or below the highest tier in service is not offered.
- R10: Once `irq_req` rises, it and `irq_vec` stay unchanged until the cycle in which `irq_ack` is high.
- R11: An acknowledge marks the offered tier in service, and `irq_req` is low in the cycle after the acknowledge. An `irq_ret` pulse clears only the highest tier that is in service.
- R12: A second power-management request is not offered while a power-management handler is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 priority, 2 extension |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| irq_src | input | 12 | Level request lines; line 11 is power-management |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_vec | output | 4 | Line number of the offered interrupt |
| irq_ack | input | 1 | Core takes the offered interrupt |
| irq_ret | input | 1 | Return-from-interrupt pulse |

## Verification
The bench builds the block with the package defaults: twelve lines, seven of them in the base register and four in the extension register. With these values every tier and the extension bit fields are in play. The bench drives nests three deep (low, high, power-management) and unwinds them one return at a time. Along the way it shows that a return exposes only the next tier down. It also holds a request unacknowledged while a higher one arrives, which checks that the offered vector does not move.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    localparam int unsigned N_SRC    = 12;
    localparam int unsigned N_ORD    = N_SRC - 1;
    localparam int unsigned PM_LINE  = N_SRC - 1;
    localparam int unsigned N_BASE   = 7;
    localparam int unsigned N_EXTRA  = N_ORD - N_BASE;
    localparam int unsigned VEC_W    = $clog2(N_SRC);
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned N_TIER   = 3;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_PRIO   = 2'd1;
    localparam logic [ADDR_W-1:0] A_EXT    = 2'd2;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_PM   = 2'd3
    } lvl_e;

    typedef struct packed {
        logic             gbl;
        logic [N_ORD-1:0] en;
        logic [N_ORD-1:0] hi;
    } cfg_t;

    typedef struct packed {
        logic valid;
        lvl_e lvl;
        vec_t vec;
    } pick_t;

    function automatic lvl_e top_tier(input logic [N_TIER-1:0] isr);
        lvl_e r;
        r = LVL_NONE;
        if (isr[0]) r = LVL_LOW;
        if (isr[1]) r = LVL_HIGH;
        if (isr[2]) r = LVL_PM;
        return r;
    endfunction

    function automatic logic [N_TIER-1:0] drop_top(input logic [N_TIER-1:0] isr);
        logic [N_TIER-1:0] r;
        r = isr;
        if (isr[2])      r[2] = 1'b0;
        else if (isr[1]) r[1] = 1'b0;
        else             r[0] = 1'b0;
        return r;
    endfunction

    function automatic logic [N_TIER-1:0] tier_bit(input lvl_e l);
        logic [N_TIER-1:0] r;
        case (l)
            LVL_LOW:  r = 3'b001;
            LVL_HIGH: r = 3'b010;
            LVL_PM:   r = 3'b100;
            default:  r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nirq_regfile.sv
module nirq_regfile
    import nirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg
);

    logic                gbl_q;
    logic [N_BASE-1:0]   en_base_q;
    logic [N_BASE-1:0]   hi_base_q;
    logic [N_EXTRA-1:0]  en_ext_q;
    logic [N_EXTRA-1:0]  hi_ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gbl_q     <= 1'b0;
            en_base_q <= '0;
            hi_base_q <= '0;
            en_ext_q  <= '0;
            hi_ext_q  <= '0;
        end else if (wr) begin
            case (addr)
                A_ENABLE: begin
                    gbl_q     <= wdata[DATA_W-1];
                    en_base_q <= wdata[N_BASE-1:0];
                end
                A_PRIO: begin
                    hi_base_q <= wdata[N_BASE-1:0];
                end
                A_EXT: begin
                    en_ext_q <= wdata[N_EXTRA-1:0];
                    hi_ext_q <= wdata[4 +: N_EXTRA];
                end
                default: ;
            endcase
        end
    end

    logic [DATA_W-1:0] ext_word;

    always_comb begin
        ext_word = '0;
        ext_word[N_EXTRA-1:0] = en_ext_q;
        ext_word[4 +: N_EXTRA] = hi_ext_q;
    end

    always_comb begin
        case (addr)
            A_ENABLE: rdata = {gbl_q, en_base_q};
            A_PRIO:   rdata = {1'b0, hi_base_q};
            A_EXT:    rdata = ext_word;
            default:  rdata = '0;
        endcase
    end

    assign cfg.gbl = gbl_q;
    assign cfg.en  = {en_ext_q, en_base_q};
    assign cfg.hi  = {hi_ext_q, hi_base_q};

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (cfg.gbl == 1'b0 && cfg.en == '0 && cfg.hi == '0));

endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
    import nirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src,
    input  cfg_t             cfg,
    input  lvl_e             ceiling,
    output pick_t            cand
);

    logic [N_ORD-1:0] elig;
    logic             hi_any;
    logic             lo_any;
    vec_t             hi_vec;
    vec_t             lo_vec;
    pick_t            best;

    genvar g;
    generate
        for (g = 0; g < int'(N_ORD); g++) begin : g_elig
            assign elig[g] = src[g] & cfg.en[g] & cfg.gbl;
        end
    endgenerate

    // Scan downward so the lowest line number on each tier wins.
    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_vec = '0;
        lo_vec = '0;
        for (int i = int'(N_ORD) - 1; i >= 0; i--) begin
            if (elig[i] && cfg.hi[i]) begin
                hi_any = 1'b1;
                hi_vec = vec_t'(i);
            end
            if (elig[i] && !cfg.hi[i]) begin
                lo_any = 1'b1;
                lo_vec = vec_t'(i);
            end
        end
    end

    always_comb begin
        best = '{valid: 1'b0, lvl: LVL_NONE, vec: '0};
        if (src[PM_LINE]) begin
            best = '{valid: 1'b1, lvl: LVL_PM, vec: vec_t'(PM_LINE)};
        end else if (hi_any) begin
            best = '{valid: 1'b1, lvl: LVL_HIGH, vec: hi_vec};
        end else if (lo_any) begin
            best = '{valid: 1'b1, lvl: LVL_LOW, vec: lo_vec};
        end
    end

    always_comb begin
        cand = best;
        cand.valid = best.valid && (best.lvl > ceiling);
    end

    assert_global_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.gbl && cand.valid) |-> (cand.vec == vec_t'(PM_LINE)));

    assert_pm_always_R4: assert property (@(posedge clk) disable iff (rst)
        (src[PM_LINE] && ceiling != LVL_PM) |-> (cand.valid && cand.lvl == LVL_PM));

endmodule

// File: rtl/nirq_service.sv
module nirq_service
    import nirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pick_t cand,
    input  logic  ack,
    input  logic  ret,
    output lvl_e  ceiling,
    output logic  req,
    output vec_t  vec
);

    logic [N_TIER-1:0] isr_q;
    logic [N_TIER-1:0] isr_n;
    logic              pend_q;
    lvl_e              pend_lvl_q;
    vec_t              pend_vec_q;
    logic              take;

    assign take    = pend_q && ack;
    assign ceiling = top_tier(isr_q);

    always_comb begin
        isr_n = isr_q;
        if (ret) isr_n = drop_top(isr_n);
        if (take) isr_n = isr_n | tier_bit(pend_lvl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q      <= '0;
            pend_q     <= 1'b0;
            pend_lvl_q <= LVL_NONE;
            pend_vec_q <= '0;
        end else begin
            isr_q <= isr_n;
            if (pend_q) begin
                if (ack) pend_q <= 1'b0;
            end else if (cand.valid) begin
                pend_q     <= 1'b1;
                pend_lvl_q <= cand.lvl;
                pend_vec_q <= cand.vec;
            end
        end
    end

    assign req = pend_q;
    assign vec = pend_vec_q;

    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(vec)));

    assert_drop_after_ack_R11: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);

    assert_ret_unwinds_one_R11: assert property (@(posedge clk) disable iff (rst)
        (ret && !take && isr_q != '0) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

    assert_strictly_above_R9: assert property (@(posedge clk) disable iff (rst)
        req |-> (pend_lvl_q > ceiling));

    assert_pm_not_nested_R12: assert property (@(posedge clk) disable iff (rst)
        isr_q[2] |-> !(req && pend_lvl_q == LVL_PM));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  irq_src,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_ack,
    input  logic              irq_ret
);

    cfg_t  cfg;
    pick_t cand;
    lvl_e  ceiling;

    nirq_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    nirq_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .src     (irq_src),
        .cfg     (cfg),
        .ceiling (ceiling),
        .cand    (cand)
    );

    nirq_service u_svc (
        .clk     (clk),
        .rst     (rst),
        .cand    (cand),
        .ack     (irq_ack),
        .ret     (irq_ret),
        .ceiling (ceiling),
        .req     (irq_req),
        .vec     (irq_vec)
    );

endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [11:0] irq_src = '0;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];
    logic prev_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: each new offer is matched against the next expected vector.
    always @(negedge clk) begin
        if (rst) begin
            prev_req <= 1'b0;
        end else begin
            if (irq_req && !prev_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected offer", int'(irq_vec), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(irq_vec) == e, "R5/R6 offered vector", int'(irq_vec), e);
                end
            end
            prev_req <= irq_req;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == e, tag, int'(reg_rdata), int'(e));
    endtask

    task automatic set_src(input int line, input logic v);
        @(posedge clk); #1;
        irq_src[line] = v;
    endtask

    task automatic take(input string tag);
        int waited;
        waited = 0;
        @(negedge clk);
        while (!irq_req && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(irq_req, tag, int'(irq_req), 1);
        @(posedge clk); #1;
        irq_ack = 1'b1;
        @(posedge clk); #1;
        irq_ack = 1'b0;
        @(negedge clk);
        chk(!irq_req, "R11 request drops after ack", int'(irq_req), 0);
    endtask

    task automatic ret_pulse();
        @(posedge clk); #1;
        irq_ret = 1'b1;
        @(posedge clk); #1;
        irq_ret = 1'b0;
    endtask

    task automatic quiet(input string tag);
        tick(4);
        @(negedge clk);
        chk(!irq_req, tag, int'(irq_req), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk(!irq_req, "R1 no request after reset", int'(irq_req), 0);
        rd(2'd0, 8'h00, "R1 enable reg reset");
        rd(2'd1, 8'h00, "R1 priority reg reset");
        rd(2'd2, 8'h00, "R1 extension reg reset");

        // R3 global bit clear masks line 0
        set_src(0, 1'b1);
        wr(2'd0, 8'h01);
        quiet("R3 global enable off masks");
        // R2 own bit plus global bit
        exp_q.push_back(0);
        wr(2'd0, 8'h81);
        take("R2 line 0 offered");
        set_src(0, 1'b0);
        ret_pulse();

        // R6 polling order on the low tier, including an extension line
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h0F);
        rd(2'd2, 8'h0F, "R7 extension readback");
        exp_q.push_back(3);
        @(posedge clk); #1;
        irq_src[3] = 1'b1; irq_src[5] = 1'b1; irq_src[9] = 1'b1;
        take("R6 lowest line first");
        quiet("R9 same tier not offered");
        set_src(3, 1'b0);
        exp_q.push_back(5);
        ret_pulse();
        take("R6 next line 5");
        set_src(5, 1'b0);
        exp_q.push_back(9);
        ret_pulse();
        take("R6 extension line 9");
        set_src(9, 1'b0);
        ret_pulse();

        // R5 / R7 tiers: line 4 and line 8 high, line 1 low
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h2F);
        exp_q.push_back(4);
        @(posedge clk); #1;
        irq_src[1] = 1'b1; irq_src[4] = 1'b1; irq_src[8] = 1'b1;
        take("R5 high tier first");
        quiet("R9 high peer not offered");
        set_src(4, 1'b0);
        exp_q.push_back(8);
        ret_pulse();
        take("R7 extension high line 8");
        set_src(8, 1'b0);
        exp_q.push_back(1);
        ret_pulse();
        take("R5 low line after high");
        set_src(1, 1'b0);
        ret_pulse();

        // R8 three-deep nesting, R12, R11 unwinding
        exp_q.push_back(0);
        set_src(0, 1'b1);
        take("R8 low handler");
        exp_q.push_back(4);
        set_src(4, 1'b1);
        take("R8 high preempts low");
        exp_q.push_back(11);
        set_src(11, 1'b1);
        take("R8 power preempts high");
        quiet("R12 no second power offer");
        exp_q.push_back(11);
        ret_pulse();
        take("R12 power offered after return");
        @(posedge clk); #1;
        irq_src[11] = 1'b0; irq_src[4] = 1'b0;
        ret_pulse();
        set_src(1, 1'b1);
        quiet("R11 return cleared only top tier");
        ret_pulse();
        quiet("R11 low still in service");
        set_src(0, 1'b0);
        exp_q.push_back(1);
        ret_pulse();
        take("R11 low line after full unwind");
        set_src(1, 1'b0);
        ret_pulse();

        // R4 power line with everything disabled
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        exp_q.push_back(11);
        set_src(11, 1'b1);
        take("R4 power ignores enables");
        set_src(11, 1'b0);
        ret_pulse();

        // R10 hold while a higher request arrives
        wr(2'd0, 8'hC0);
        exp_q.push_back(6);
        set_src(6, 1'b1);
        tick(3);
        set_src(11, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(irq_req && irq_vec == 4'd6, "R10 held vector", int'(irq_vec), 6);
        end
        exp_q.push_back(11);
        take("R10 held offer taken");
        take("R8 power after low taken");
        @(posedge clk); #1;
        irq_src[11] = 1'b0; irq_src[6] = 1'b0;
        ret_pulse();
        ret_pulse();
        quiet("R11 all unwound, idle");

        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule